// File: doc/BRIEF.md
# Two-Wire Debug Port Master

This block is the host-side engine for a small on-chip debug port of the kind found on 8051-style microcontrollers. It owns three target lines: a debug clock, a single half-duplex data line (driven through an output enable) and an active-low target reset. On request it performs the debug-entry handshake. It also runs byte transfers: an opcode and up to three operand bytes are shifted out, and then, when the command calls for it, the data line is released and one or two reply bytes are shifted in.

Commands arrive on a valid/busy interface. A mode field picks one of three actions. Debug entry needs no operands. A generic transfer sends the given operands, and whether a reply byte follows depends only on the opcode. A native transfer decodes the fixed opcodes: it knows which commands return two bytes and how many bytes follow an instruction-injection opcode. When a command finishes, a single-cycle done strobe marks the moment its reply is valid. The debug clock half-period is derived from the system clock and the target's clock limit, so the target is never clocked faster than it allows.

Top module: `dbg2w_master`

## Requirements
- R1: After reset, dbg_clk, dbg_dout, dbg_rst_n and dbg_oe are all 1, busy is 0 and rsp_done is 0.
- R2: A command with cmd_mode[1]=1 runs debug entry. At acceptance, dbg_clk and dbg_rst_n go low, with the data line driven high. dbg_clk then makes exactly two rising edges while dbg_rst_n stays low. After that, dbg_rst_n returns high while dbg_clk is low, and done follows one half-period later.
- R3: Every level of dbg_clk lasts HALF = SYS_HZ/(2*DBG_MAX_HZ)+1 system cycles. At the default (250 MHz, 30 MHz) HALF is 5, giving a 25 MHz debug clock.
- R4: A transfer first holds dbg_clk low for one half-period. It then sends the opcode followed by the operand bytes cmd_args[23:16], [15:8] and [7:0], in that order, each byte MSB first. dbg_dout takes a new bit at each rising edge of dbg_clk.
- R5: In generic mode (cmd_mode=00), cmd_nargs operand bytes (0..3) are sent. A single reply byte is read if and only if bit 2 of cmd_op is 1.
- R6: In native mode (cmd_mode=01), opcodes 0x28 and 0x68 read two reply bytes. Every other opcode reads one. cmd_nargs operand bytes are sent unless R7 applies.
- R7: In native mode, opcodes 0x54..0x57 (instruction injection) send exactly cmd_op[1:0] operand bytes, whatever the value of cmd_nargs, and read one reply byte.
- R8: When a reply follows, dbg_oe drops at the falling edge that ends the last written bit. dbg_clk then stays low for two half-periods before the first read rising edge.
- R9: Reply bits are sampled from dbg_din at each falling edge of dbg_clk, MSB first. With two bytes, the first byte lands in rsp_data[15:8]. With one byte, rsp_data[15:8] is 0. With no reply, rsp_data is 0.
- R10: busy rises on acceptance and falls in the cycle where rsp_done pulses for one cycle. cmd_valid is ignored while busy, and the line activity is unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_mode | input | 2 | 00 generic, 01 native, 1x debug entry |
| cmd_op | input | 8 | Opcode byte |
| cmd_args | input | 24 | Operand bytes, first in [23:16] |
| cmd_nargs | input | 2 | Number of operand bytes |
| busy | output | 1 | Command in progress |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_data | output | 16 | Reply bytes, valid at rsp_done |
| dbg_clk | output | 1 | Debug clock to target |
| dbg_rst_n | output | 1 | Active-low target reset |
| dbg_dout | output | 1 | Data line output value |
| dbg_oe | output | 1 | Data line output enable |
| dbg_din | input | 1 | Data line value from target |

## Verification
The hardest state to reach is the turnaround. It calls for the last write bit, the release of the line and the first read edge to fall in exactly the right half-periods, with a target answering in between. The bench therefore models the target as a queue of reply bits, popped at each debug-clock rising edge while the line is released. It predicts every half-period level of all four line outputs and busy, and compares them on each system cycle. Injection opcodes are given a cmd_nargs that disagrees with their low bits, and one command holds cmd_valid asserted with a different request during its transfer.

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int SYS_HZ     = 250_000_000,
  parameter int DBG_MAX_HZ = 30_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_mode,
  input  logic [7:0]  cmd_op,
  input  logic [23:0] cmd_args,
  input  logic [1:0]  cmd_nargs,
  output logic        busy,
  output logic        rsp_done,
  output logic [15:0] rsp_data,
  output logic        dbg_clk,
  output logic        dbg_rst_n,
  output logic        dbg_dout,
  output logic        dbg_oe,
  input  logic        dbg_din
);
  localparam int HALF = SYS_HZ / (2 * DBG_MAX_HZ) + 1;
  localparam int DW   = $clog2(HALF + 1);

  typedef enum logic [2:0] {IDLE, ENTRY, SHOUT, TURN, SHIN} st_t;

  st_t         st;
  logic [DW-1:0] div;
  logic        ph;
  logic [5:0]  cnt;
  logic [2:0]  step;
  logic [1:0]  nrd;
  logic [31:0] sh;
  logic [15:0] rsh;

  wire tick   = (div == DW'(HALF - 1));
  wire accept = (st == IDLE) && cmd_valid;
  wire inj    = (cmd_mode == 2'b01) && (cmd_op[7:2] == 6'b010101);
  wire [1:0] n_args = inj ? cmd_op[1:0] : cmd_nargs;

  logic [1:0] n_rep;
  always_comb begin
    if (cmd_mode == 2'b01)
      n_rep = (!inj && (cmd_op == 8'h28 || cmd_op == 8'h68)) ? 2'd2 : 2'd1;
    else
      n_rep = cmd_op[2] ? 2'd1 : 2'd0;
  end

  assign busy     = (st != IDLE);
  assign rsp_data = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else if (st == IDLE || tick) div <= '0;
    else div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      ph        <= 1'b0;
      cnt       <= '0;
      step      <= '0;
      nrd       <= '0;
      sh        <= '0;
      rsh       <= '0;
      rsp_done  <= 1'b0;
      dbg_clk   <= 1'b1;
      dbg_rst_n <= 1'b1;
      dbg_dout  <= 1'b1;
      dbg_oe    <= 1'b1;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          dbg_clk <= 1'b0;
          dbg_oe  <= 1'b1;
          step    <= '0;
          if (cmd_mode[1]) begin
            st        <= ENTRY;
            dbg_rst_n <= 1'b0;
            dbg_dout  <= 1'b1;
          end else begin
            st  <= SHOUT;
            ph  <= 1'b0;
            sh  <= {cmd_op, cmd_args};
            cnt <= {3'(n_args) + 3'd1, 3'b000} - 6'd1;
            nrd <= n_rep;
            rsh <= '0;
          end
        end
        ENTRY: if (tick) begin
          step <= step + 3'd1;
          if (step < 3'd4) dbg_clk <= ~dbg_clk;
          else if (step == 3'd4) dbg_rst_n <= 1'b1;
          else begin
            st       <= IDLE;
            rsp_done <= 1'b1;
          end
        end
        SHOUT: if (tick) begin
          if (!ph) begin
            dbg_clk  <= 1'b1;
            dbg_dout <= sh[31];
            sh       <= {sh[30:0], 1'b0};
            ph       <= 1'b1;
          end else begin
            dbg_clk <= 1'b0;
            ph      <= 1'b0;
            if (cnt != 6'd0) cnt <= cnt - 6'd1;
            else if (nrd != 2'd0) begin
              st     <= TURN;
              dbg_oe <= 1'b0;
              step   <= '0;
            end else begin
              st       <= IDLE;
              rsp_done <= 1'b1;
            end
          end
        end
        TURN: if (tick) begin
          if (step == 3'd0) step <= 3'd1;
          else begin
            st      <= SHIN;
            dbg_clk <= 1'b1;
            ph      <= 1'b1;
            cnt     <= (nrd == 2'd2) ? 6'd15 : 6'd7;
          end
        end
        SHIN: if (tick) begin
          if (ph) begin
            dbg_clk <= 1'b0;
            ph      <= 1'b0;
            rsh     <= {rsh[14:0], dbg_din};
            if (cnt != 6'd0) cnt <= cnt - 6'd1;
            else begin
              st       <= IDLE;
              rsp_done <= 1'b1;
            end
          end else begin
            dbg_clk <= 1'b1;
            ph      <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg2w_master_chk.sv
module dbg2w_master_chk #(
  parameter int HALF = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic rsp_done,
  input logic dbg_clk,
  input logic dbg_rst_n,
  input logic dbg_dout,
  input logic dbg_oe
);
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> !busy); // R10
  AST_BUSY_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> rsp_done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> ($stable(dbg_clk) && $stable(dbg_rst_n) && $stable(dbg_oe))); // R10
  AST_RST_RELEASE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(dbg_rst_n) |-> !dbg_clk); // R2
  AST_ENTRY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !dbg_rst_n |-> (dbg_oe && dbg_dout)); // R2
  AST_TURN_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(dbg_oe) |-> !dbg_clk); // R8
  AST_CLK_MIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((HALF > 1) && !$stable(dbg_clk)) |=> $stable(dbg_clk)); // R3
endmodule

bind dbg2w_master dbg2w_master_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .rsp_done(rsp_done),
  .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n), .dbg_dout(dbg_dout), .dbg_oe(dbg_oe)
);

// File: tb/sim_dbg2w_master.sv
module sim_dbg2w_master;
  localparam int HALF = 250_000_000 / (2 * 30_000_000) + 1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_mode = 0;
  logic [7:0] cmd_op = 0;
  logic [23:0] cmd_args = 0;
  logic [1:0] cmd_nargs = 0;
  logic busy, rsp_done, dbg_clk, dbg_rst_n, dbg_dout, dbg_oe;
  logic [15:0] rsp_data;
  logic dbg_din = 0;
  int total = 0, bad = 0, cyc = 0;
  bit rq[$];

  always #2 clk = ~clk;

  dbg2w_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_op(cmd_op),
    .cmd_args(cmd_args), .cmd_nargs(cmd_nargs), .busy(busy), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n), .dbg_dout(dbg_dout),
    .dbg_oe(dbg_oe), .dbg_din(dbg_din)
  );

  // target model: new reply bit on each rising debug clock while the line is released
  always @(posedge dbg_clk) if (!dbg_oe && rq.size() > 0) dbg_din <= rq.pop_front();

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%0d exp<=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq_tag, act, exp);
    end
  endtask

  // one half-period level: {clk,rst_n,oe,dout,busy} compared every system cycle
  task automatic lvl(input logic c, input logic r, input logic o, input logic d, input bit dc,
                     input logic b, input bit dn, input bit dchk, input logic [15:0] ed, input string tag);
    for (int k = 0; k < HALF; k++) begin
      logic [4:0] act, exp;
      @(negedge clk);
      act = {dbg_clk, dbg_rst_n, dbg_oe, dc ? dbg_dout : 1'b0, busy};
      exp = {c, r, o, dc ? d : 1'b0, b};
      chk(act == exp, tag, 32'(act), 32'(exp));
      chk(rsp_done == (dn && k == 0), "R10 done", 32'(rsp_done), 32'(dn && k == 0));
      if (dn && k == 0 && dchk) chk(rsp_data == ed, "R9 data", 32'(rsp_data), 32'(ed));
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [7:0] op, input logic [23:0] a, input logic [1:0] na);
    @(negedge clk);
    cmd_valid = 1; cmd_mode = m; cmd_op = op; cmd_args = a; cmd_nargs = na;
  endtask

  task automatic entry(input logic [1:0] m);
    issue(m, 8'h00, 24'h0, 2'd0);
    lvl(0, 0, 1, 1, 1, 1, 0, 0, 0, "R2 entry low");
    cmd_valid = 0;
    lvl(1, 0, 1, 1, 1, 1, 0, 0, 0, "R2 rise1");
    lvl(0, 0, 1, 1, 1, 1, 0, 0, 0, "R2 fall1");
    lvl(1, 0, 1, 1, 1, 1, 0, 0, 0, "R2 rise2");
    lvl(0, 0, 1, 1, 1, 1, 0, 0, 0, "R2 fall2");
    lvl(0, 1, 1, 1, 1, 1, 0, 0, 0, "R2 release");
    lvl(0, 1, 1, 1, 1, 0, 1, 0, 0, "R2 idle");
  endtask

  task automatic xfer(input logic [1:0] m, input logic [7:0] op, input logic [23:0] a,
                      input logic [1:0] na, input logic [15:0] rep, input bit hold);
    int nA, nR, nb;
    bit inj;
    logic [7:0] wb [4];
    logic [15:0] ed;
    inj = (m == 2'b01) && (op >= 8'h54) && (op <= 8'h57);
    nA = inj ? int'(op - 8'h54) : int'(na);
    if (m == 2'b01) nR = (!inj && (op == 8'h28 || op == 8'h68)) ? 2 : 1;
    else nR = op[2] ? 1 : 0;
    ed = (nR == 2) ? rep : (nR == 1) ? {8'h00, rep[7:0]} : 16'h0;
    for (int j = 0; j < nR * 8; j++)
      rq.push_back((nR == 2) ? rep[15 - j] : rep[7 - j]);
    wb[0] = op; wb[1] = a[23:16]; wb[2] = a[15:8]; wb[3] = a[7:0];
    nb = (nA + 1) * 8;
    issue(m, op, a, na);
    lvl(0, 1, 1, 0, 0, 1, 0, 0, 0, "R4 lead");
    if (hold) begin cmd_mode = 2'b10; cmd_op = 8'hFF; cmd_nargs = 2'd3; end
    else cmd_valid = 0;
    for (int i = 0; i < nb; i++) begin
      logic bt;
      bt = wb[i / 8][7 - (i % 8)];
      lvl(1, 1, 1, bt, 1, 1, 0, 0, 0, "R4 bit high");
      if (i == 0) cmd_valid = 0;
      if (i == nb - 1 && nR == 0) lvl(0, 1, 1, bt, 1, 0, 1, 1, ed, "R5 end write");
      else if (i == nb - 1) lvl(0, 1, 0, 0, 0, 1, 0, 0, 0, "R8 turn A");
      else lvl(0, 1, 1, bt, 1, 1, 0, 0, 0, "R4 bit low");
    end
    if (nR > 0) begin
      lvl(0, 1, 0, 0, 0, 1, 0, 0, 0, "R8 turn B");
      for (int j = 0; j < nR * 8; j++) begin
        lvl(1, 1, 0, 0, 0, 1, 0, 0, 0, "R9 read high");
        if (j == nR * 8 - 1) lvl(0, 1, 0, 0, 0, 0, 1, 1, ed, "R9 read end");
        else lvl(0, 1, 0, 0, 0, 1, 0, 0, 0, "R9 read low");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({dbg_clk, dbg_dout, dbg_rst_n, dbg_oe, busy, rsp_done} == 6'b111100, "R1 reset",
        32'({dbg_clk, dbg_dout, dbg_rst_n, dbg_oe, busy, rsp_done}), 32'h3C);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({dbg_clk, dbg_dout, dbg_rst_n, dbg_oe, busy} == 5'b11110, "R1 idle",
        32'({dbg_clk, dbg_dout, dbg_rst_n, dbg_oe, busy}), 32'h1E);
    chk(HALF == 5, "R3 half", HALF, 5);
    entry(2'b10);                              // R2
    xfer(2'b00, 8'h10, 24'hA1B2C3, 2'd2, 16'h0, 0);   // R5 no reply
    xfer(2'b00, 8'h24, 24'h0, 2'd0, 16'h00A5, 0);     // R5 reply on bit 2
    xfer(2'b00, 8'h04, 24'h5A3C96, 2'd3, 16'h0081, 0); // R4 three operands
    xfer(2'b01, 8'h28, 24'h0, 2'd0, 16'h1234, 1);     // R6 two bytes, R10 hold
    xfer(2'b01, 8'h68, 24'h0, 2'd0, 16'hBEEF, 0);     // R6
    xfer(2'b01, 8'h1D, 24'h010000, 2'd1, 16'h003C, 0); // R6 one byte
    xfer(2'b01, 8'h44, 24'h0, 2'd0, 16'h00FF, 0);     // R6
    xfer(2'b01, 8'h57, 24'h75C751, 2'd0, 16'h0066, 0); // R7 three bytes despite nargs
    xfer(2'b01, 8'h55, 24'hA30000, 2'd3, 16'h0099, 0); // R7 one byte despite nargs
    entry(2'b11);                              // R2
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule